// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands and turns the outcome into a four-bit condition code (negative, zero, carry, overflow) for the top field of a 32-bit status word. One input selects the operand width, either single precision or double precision. A second input selects the compare flavour. The quiet flavour tolerates quiet NaNs without complaint. The signalling flavour treats any NaN as an invalid operation. Both widths use the same four condition codes, and one of those codes is reserved for an unordered result.

A caller presents both operands and the low 28 bits of the current status word, then pulses `cmp_vld_i`. One clock later the unit registers its outputs. These are the condition code, the rebuilt status word (new code on top, the caller's low field unchanged), a one-cycle update strobe and, when the operands call for it, a one-cycle invalid-operation pulse. In cycles without a request the outputs keep their last value.

Top module: `fpcmp_flags`

## Requirements
- R1: When the operands are equal the code is 4'b0110. Positive zero and negative zero count as equal.
- R2: When operand A is less than operand B the code is 4'b1000.
- R3: When operand A is greater than operand B the code is 4'b0010.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero) the result is unordered and the code is 4'b0011.
- R5: On an update, `stat_o[31:28]` carries the code and `stat_o[27:0]` equals the `stat_low_i` value sampled with the request.
- R6: With `dbl_i`=1 the full 64-bit operands are compared (11-bit exponent, 52-bit fraction). With `dbl_i`=0 only bits 31:0 are compared (8-bit exponent, 23-bit fraction), bits 63:32 have no effect, and the codes are the same as in double mode.
- R7: With `sig_cmp_i`=0 (quiet), `inv_o` pulses only when at least one operand is a signalling NaN, meaning a NaN whose top fraction bit is 0.
- R8: With `sig_cmp_i`=1 (signalling), `inv_o` pulses whenever either operand is a NaN of any kind.
- R9: Infinities are ordered values: -inf is below every finite value, +inf is above every finite value, and equal infinities compare as equal.
- R10: The outputs are registered one cycle after `cmp_vld_i`. `upd_o` is high for exactly that cycle. `inv_o` is only ever high together with `upd_o`. Without a request, `nzcv_o` and `stat_o` hold their values.
- R11: After a synchronous reset `nzcv_o`, `stat_o`, `upd_o` and `inv_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_vld_i | input | 1 | Compare request strobe |
| dbl_i | input | 1 | 1: double precision, 0: single precision in bits 31:0 |
| sig_cmp_i | input | 1 | 1: signalling compare, 0: quiet compare |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| stat_low_i | input | 28 | Low field of the status word to be preserved |
| nzcv_o | output | 4 | Registered condition code |
| stat_o | output | 32 | Rebuilt status word |
| upd_o | output | 1 | One-cycle update strobe |
| inv_o | output | 1 | One-cycle invalid-operation pulse |

## Verification
The assertions assume the caller drives `cmp_vld_i`, `sig_cmp_i` and `stat_low_i` to known values in every cycle after reset, because the properties sample them with `$past`. They also assume that a request in every cycle is legal, with no back-pressure. The bench drives all inputs at the falling edge, holding them for a whole period. It sends requests back to back and also leaves idle gaps between them, so that both the strobe timing and the hold behaviour are exercised. The operand patterns include both zero signs, both infinities, subnormals, quiet and signalling NaNs in each width, and single-precision requests with nonzero upper operand bits.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Condition codes written to the top nibble of the status word
  typedef enum logic [3:0] {
    CC_LT = 4'b1000,
    CC_EQ = 4'b0110,
    CC_GT = 4'b0010,
    CC_UN = 4'b0011
  } cc_e;

  // Per-operand class summary
  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } fcls_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int MAG_W = 63
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output fcls_t                cls_o,
  output logic [MAG_W-1:0]     mag_o
);
  localparam int BODY_W = EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             man_nz;

  assign exp_f   = val_i[BODY_W-1 -: EXP_W];
  assign man_f   = val_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls_o.sign = val_i[BODY_W];
    cls_o.zero = ~(|val_i[BODY_W-1:0]);
    cls_o.nan  = exp_max & man_nz;
    // quiet bit is the top fraction bit; clear means signalling
    cls_o.snan = exp_max & man_nz & ~man_f[MAN_W-1];
  end

  // zero-extended magnitude so both widths share one comparator
  assign mag_o = {{(MAG_W-BODY_W){1'b0}}, val_i[BODY_W-1:0]};

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  fcls_t            a_cls_i,
  input  fcls_t            b_cls_i,
  input  logic [MAG_W-1:0] a_mag_i,
  input  logic [MAG_W-1:0] b_mag_i,
  input  logic             sig_cmp_i,
  output cc_e              cc_o,
  output logic             inv_o
);
  logic mag_eq;
  logic mag_lt;

  assign mag_eq = (a_mag_i == b_mag_i);
  assign mag_lt = (a_mag_i <  b_mag_i);

  always_comb begin
    if (a_cls_i.nan || b_cls_i.nan) begin
      cc_o = CC_UN;
    end else if (a_cls_i.zero && b_cls_i.zero) begin
      cc_o = CC_EQ;
    end else if (a_cls_i.sign != b_cls_i.sign) begin
      cc_o = a_cls_i.sign ? CC_LT : CC_GT;
    end else if (mag_eq) begin
      cc_o = CC_EQ;
    end else if (!a_cls_i.sign) begin
      cc_o = mag_lt ? CC_LT : CC_GT;
    end else begin
      cc_o = mag_lt ? CC_GT : CC_LT;
    end
  end

  always_comb begin
    if (sig_cmp_i) inv_o = a_cls_i.nan  | b_cls_i.nan;
    else           inv_o = a_cls_i.snan | b_cls_i.snan;
  end

endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
#(
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23,
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  parameter int WORD_W  = 32,
  parameter int CC_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmp_vld_i,
  input  logic                   dbl_i,
  input  logic                   sig_cmp_i,
  input  logic [63:0]            opa_i,
  input  logic [63:0]            opb_i,
  input  logic [WORD_W-CC_W-1:0] stat_low_i,
  output logic [CC_W-1:0]        nzcv_o,
  output logic [WORD_W-1:0]      stat_o,
  output logic                   upd_o,
  output logic                   inv_o
);
  localparam int OP_W  = 1 + DBL_EXP + DBL_MAN;
  localparam int SGL_W = 1 + SGL_EXP + SGL_MAN;
  localparam int MAG_W = OP_W - 1;
  localparam int N_FMT = 2;

  fcls_t            cls_a [N_FMT];
  fcls_t            cls_b [N_FMT];
  logic [MAG_W-1:0] mag_a [N_FMT];
  logic [MAG_W-1:0] mag_b [N_FMT];

  // index 0: single precision, index 1: double precision
  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int E_W = (g == 0) ? SGL_EXP : DBL_EXP;
    localparam int M_W = (g == 0) ? SGL_MAN : DBL_MAN;
    localparam int T_W = (g == 0) ? SGL_W   : OP_W;

    fpcmp_classify #(.EXP_W(E_W), .MAN_W(M_W), .MAG_W(MAG_W)) u_cls_a (
      .val_i (opa_i[T_W-1:0]),
      .cls_o (cls_a[g]),
      .mag_o (mag_a[g])
    );

    fpcmp_classify #(.EXP_W(E_W), .MAN_W(M_W), .MAG_W(MAG_W)) u_cls_b (
      .val_i (opb_i[T_W-1:0]),
      .cls_o (cls_b[g]),
      .mag_o (mag_b[g])
    );
  end

  fcls_t            sel_cls_a, sel_cls_b;
  logic [MAG_W-1:0] sel_mag_a, sel_mag_b;

  always_comb begin
    sel_cls_a = dbl_i ? cls_a[1] : cls_a[0];
    sel_cls_b = dbl_i ? cls_b[1] : cls_b[0];
    sel_mag_a = dbl_i ? mag_a[1] : mag_a[0];
    sel_mag_b = dbl_i ? mag_b[1] : mag_b[0];
  end

  cc_e  cc_nxt;
  logic inv_nxt;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .a_cls_i   (sel_cls_a),
    .b_cls_i   (sel_cls_b),
    .a_mag_i   (sel_mag_a),
    .b_mag_i   (sel_mag_b),
    .sig_cmp_i (sig_cmp_i),
    .cc_o      (cc_nxt),
    .inv_o     (inv_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nzcv_o <= '0;
      stat_o <= '0;
      upd_o  <= 1'b0;
      inv_o  <= 1'b0;
    end else begin
      upd_o <= cmp_vld_i;
      inv_o <= cmp_vld_i & inv_nxt;
      if (cmp_vld_i) begin
        nzcv_o <= cc_nxt;
        stat_o <= {cc_nxt, stat_low_i};
      end
    end
  end

endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk #(
  parameter int WORD_W = 32,
  parameter int CC_W   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmp_vld_i,
  input logic                   sig_cmp_i,
  input logic [WORD_W-CC_W-1:0] stat_low_i,
  input logic [CC_W-1:0]        nzcv_o,
  input logic [WORD_W-1:0]      stat_o,
  input logic                   upd_o,
  input logic                   inv_o
);

  AST_UPD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    cmp_vld_i |=> upd_o); // R10

  AST_UPD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !cmp_vld_i |=> !upd_o); // R10

  AST_INV_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
    inv_o |-> upd_o); // R10

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    !cmp_vld_i |=> $stable(nzcv_o)); // R10

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (nzcv_o == 4'b0110 || nzcv_o == 4'b1000 ||
               nzcv_o == 4'b0010 || nzcv_o == 4'b0011)); // R1

  AST_WORD_TOP: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (stat_o[WORD_W-1 -: CC_W] == nzcv_o)); // R5

  AST_WORD_LOW: assert property (@(posedge clk) disable iff (rst)
    cmp_vld_i |=> (stat_o[WORD_W-CC_W-1:0] == $past(stat_low_i))); // R5

  AST_ORDERED_NO_INV: assert property (@(posedge clk) disable iff (rst)
    (upd_o && nzcv_o != 4'b0011) |-> !inv_o); // R7

  AST_SIG_UN_INV: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i && sig_cmp_i) |=> (nzcv_o != 4'b0011 || inv_o)); // R8

endmodule

bind fpcmp_flags fpcmp_flags_chk #(.WORD_W(WORD_W), .CC_W(CC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmp_vld_i  (cmp_vld_i),
  .sig_cmp_i  (sig_cmp_i),
  .stat_low_i (stat_low_i),
  .nzcv_o     (nzcv_o),
  .stat_o     (stat_o),
  .upd_o      (upd_o),
  .inv_o      (inv_o)
);

// File: tb/tb_fpcmp_flags.sv
module tb_fpcmp_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_vld_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic        sig_cmp_i = 1'b0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [27:0] stat_low_i = '0;
  logic [3:0]  nzcv_o;
  logic [31:0] stat_o;
  logic        upd_o;
  logic        inv_o;

  int total = 0;
  int fails = 0;
  bit started = 0;

  logic [32:0] q_val [$];   // {inv, word}
  string       q_tag [$];
  logic [31:0] last_word = '0;

  always #4 clk = ~clk;     // 125 MHz

  fpcmp_flags dut (
    .clk(clk), .rst(rst), .cmp_vld_i(cmp_vld_i), .dbl_i(dbl_i),
    .sig_cmp_i(sig_cmp_i), .opa_i(opa_i), .opb_i(opb_i),
    .stat_low_i(stat_low_i), .nzcv_o(nzcv_o), .stat_o(stat_o),
    .upd_o(upd_o), .inv_o(inv_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: signed key ordering, NaN by fields
  function automatic logic [4:0] ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                         input logic dbl, input logic sig);
    logic an, bn, asn, bsn, as, bs;
    logic [62:0] am, bm;
    logic signed [64:0] ka, kb;
    logic [3:0] cc;
    if (dbl) begin
      an  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      bn  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      asn = an && !a[51];
      bsn = bn && !b[51];
      as  = a[63]; bs = b[63];
      am  = a[62:0]; bm = b[62:0];
    end else begin
      an  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      bn  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      asn = an && !a[22];
      bsn = bn && !b[22];
      as  = a[31]; bs = b[31];
      am  = {32'b0, a[30:0]}; bm = {32'b0, b[30:0]};
    end
    ka = as ? -$signed({2'b00, am}) : $signed({2'b00, am});
    kb = bs ? -$signed({2'b00, bm}) : $signed({2'b00, bm});
    if (an || bn)   cc = 4'b0011;
    else if (ka == kb) cc = 4'b0110;
    else if (ka < kb)  cc = 4'b1000;
    else               cc = 4'b0010;
    return {sig ? (an | bn) : (asn | bsn), cc};
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                      input logic sig, input logic [27:0] low, input string tag);
    logic [4:0] r;
    @(negedge clk);
    opa_i = a; opb_i = b; dbl_i = dbl; sig_cmp_i = sig; stat_low_i = low;
    cmp_vld_i = 1'b1;
    r = ref_cmp(a, b, dbl, sig);
    q_val.push_back({r[4], r[3:0], low});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_vld_i = 1'b0;
      opa_i = 64'hFFF8_0000_0000_0001;
      stat_low_i = 28'hABCDEF1;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (started) begin
        check(upd_o == (q_val.size() != 0), "R10 update strobe", upd_o, q_val.size() != 0);
        if (q_val.size() != 0) begin
          logic [32:0] e;
          string t;
          e = q_val.pop_front();
          t = q_tag.pop_front();
          check(nzcv_o == e[31:28], t, nzcv_o, e[31:28]);
          check(inv_o == e[32], {t, " inv"}, inv_o, e[32]);
          check(stat_o == e[31:0], "R5 status word", stat_o, e[31:0]);
          last_word = e[31:0];
        end else begin
          check(inv_o == 1'b0, "R10 inv idle", inv_o, 0);
          check(stat_o == last_word && nzcv_o == last_word[31:28],
                "R10 hold", stat_o, last_word);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(nzcv_o == 0 && stat_o == 0 && !upd_o && !inv_o, "R11 reset",
          {nzcv_o, stat_o, upd_o, inv_o}, 0);
    rst = 1'b0;
    started = 1;
    // single precision
    send(64'h3F80_0000, 64'h3F80_0000, 0, 0, 28'h1234567, "R1 eq single");
    send(64'h0000_0000, 64'h8000_0000, 0, 1, 28'h0FFFFFF, "R1 +0 vs -0 single");
    send(64'h3F80_0000, 64'h4000_0000, 0, 0, 28'h0000001, "R2 lt single");
    send(64'h4000_0000, 64'hBF80_0000, 0, 0, 28'h5555555, "R3 gt single");
    send(64'hBF80_0000, 64'hC000_0000, 0, 0, 28'hAAAAAAA, "R3 neg gt single");
    send(64'h0000_0001, 64'h0000_0000, 0, 0, 28'h0000010, "R3 subnormal gt zero");
    send(64'h7FC0_0000, 64'h3F80_0000, 0, 0, 28'h0000020, "R4 R7 qnan quiet single");
    send(64'h3F80_0000, 64'h7F80_0001, 0, 0, 28'h0000030, "R4 R7 snan quiet single");
    send(64'h7FC0_0000, 64'h3F80_0000, 0, 1, 28'h0000040, "R4 R8 qnan signalling single");
    idle(2);
    send(64'hFF80_0000, 64'hFF7F_FFFF, 0, 0, 28'h0000050, "R9 -inf lt single");
    send(64'h7F80_0000, 64'h7F80_0000, 0, 1, 28'h0000060, "R9 inf eq single");
    send({32'hFFFF_FFFF, 32'h3F80_0000}, {32'h7FF0_0000, 32'h4000_0000}, 0, 1,
         28'h0000070, "R6 upper bits ignored single");
    idle(3);
    // double precision
    send(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 28'h0000080, "R1 eq double");
    send(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 1, 0, 28'h0000090, "R1 -0 vs +0 double");
    send(64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1, 0, 28'h00000A0, "R2 neg lt double");
    send(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 1, 28'h00000B0, "R3 gt double");
    send(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 1, 0, 28'h00000C0, "R9 +inf gt double");
    send(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0000, 1, 0, 28'h00000D0, "R9 -inf lt double");
    send(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, 28'h00000E0, "R4 R7 qnan quiet double");
    send(64'h0, 64'h7FF0_0000_0000_0001, 1, 0, 28'h00000F0, "R4 R7 snan quiet double");
    send(64'hFFF8_0000_0000_0000, 64'h0, 1, 1, 28'h0000100, "R4 R8 qnan signalling double");
    send(64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 1, 0, 28'h0000110, "R6 double width");
    idle(4);
    check(q_val.size() == 0, "R10 all results seen", q_val.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule